// File: doc/BRIEF.md
# Processor Exception Entry Sequencer

This block models the moment a processor core accepts a normal interrupt (IRQ) or a fast interrupt (FIQ). It watches the two request lines together with the current program counter and the current status word. When a request is accepted, it produces in one clock edge everything the core needs to enter the handler: the new program counter pointing at the right exception vector, the return link, a saved copy of the old status word and the rewritten status word.

The status word is rewritten in a fixed way. The mode field is replaced. Bit 5 is cleared. The IRQ-disable bit and the imprecise-abort-disable bit are set. The endianness bit is loaded from a configuration input. On a fast interrupt the FIQ-disable bit is also set. A configuration input selects between the low and the high vector table. Each request is gated by its own disable bit in the incoming status word, and the fast interrupt wins when both requests are accepted in the same cycle.

All outputs are registered and keep their values between entries. A one-cycle pulse marks each entry, and a companion flag tells which kind of exception was taken.

Top module: `exc_entry_seq`

## Requirements
- R1: While `rst` is high at a rising clock edge, `new_pc`, `link`, `saved_status` and `status_out` become zero and `taken` and `taken_fiq` become low, whatever the requests are.
- R2: On an entry, `link` becomes the sampled `cur_pc` plus 4, modulo 2^32.
- R3: On an entry, `saved_status` becomes an exact copy of the sampled `cur_status`.
- R4: On an entry, `status_out` bit 5 is 0, bit 7 is 1, bit 8 is 1, bit 9 equals the sampled `endian_cfg`, and bits 31:10 equal those of the sampled `cur_status`.
- R5: On an IRQ entry, `status_out[4:0]` is 5'b10010, bit 6 keeps its sampled value, and `new_pc` is 32'h0000_0018, or 32'hFFFF_0018 when `high_vec` is 1.
- R6: On an FIQ entry, `status_out[4:0]` is 5'b10001, bit 6 is 1, and `new_pc` is 32'h0000_001C, or 32'hFFFF_001C when `high_vec` is 1.
- R7: When both requests are accepted in the same cycle, the FIQ entry is taken.
- R8: `irq_req` is ignored while `cur_status[7]` is 1, and `fiq_req` is ignored while `cur_status[6]` is 1. An ignored request leaves all outputs unchanged and `taken` low.
- R9: Inputs are sampled at a rising edge. An accepted request updates every output at that same edge, and `taken` is high for exactly that one cycle. `taken_fiq` is high only together with `taken`, on an FIQ entry. When no request is accepted, the data outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cur_pc | input | 32 | Current program counter |
| cur_status | input | 32 | Current status word |
| endian_cfg | input | 1 | Value copied into status bit 9 on entry |
| high_vec | input | 1 | 1 selects the high vector table |
| irq_req | input | 1 | Normal interrupt request |
| fiq_req | input | 1 | Fast interrupt request |
| new_pc | output | 32 | Program counter after the entry |
| link | output | 32 | Return link |
| saved_status | output | 32 | Copy of the status word taken at entry |
| status_out | output | 32 | Status word after the entry |
| taken | output | 1 | One-cycle pulse on each entry |
| taken_fiq | output | 1 | High with `taken` when the entry was a fast interrupt |

## Verification
The assertions assume that the inputs are stable around each rising edge and never unknown once reset is released. They also assume that reset is held for at least two edges, because the hold checks compare against the cleared values. The bench changes every input only on the falling edge and keeps reset high for several cycles before it releases it. Its stimulus covers both vector tables, both disable bits, simultaneous requests and a program counter that wraps around, so each assumed condition is met while each property still gets exercised.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;
  typedef enum logic [1:0] {
    EXC_NONE = 2'd0,
    EXC_IRQ  = 2'd1,
    EXC_FIQ  = 2'd2
  } exc_kind_e;

  localparam int MODE_W   = 5;
  localparam int BIT_TSTATE = 5;
  localparam int BIT_FDIS   = 6;
  localparam int BIT_IDIS   = 7;
  localparam int BIT_ADIS   = 8;
  localparam int BIT_ENDIAN = 9;

  localparam logic [MODE_W-1:0] MODE_IRQ = 5'b10010;
  localparam logic [MODE_W-1:0] MODE_FIQ = 5'b10001;
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_seq_pkg::*;
(
  input  logic      irq_req,
  input  logic      fiq_req,
  input  logic      irq_disabled,
  input  logic      fiq_disabled,
  output exc_kind_e kind
);
  logic irq_ok;
  logic fiq_ok;

  assign irq_ok = irq_req & ~irq_disabled;
  assign fiq_ok = fiq_req & ~fiq_disabled;

  // Fixed priority: the fast interrupt wins over the normal one.
  always_comb begin
    if (fiq_ok)      kind = EXC_FIQ;
    else if (irq_ok) kind = EXC_IRQ;
    else             kind = EXC_NONE;
  end
endmodule

// File: rtl/exc_vector_sel.sv
module exc_vector_sel
  import exc_seq_pkg::*;
#(
  parameter int              XLEN      = 32,
  parameter logic [XLEN-1:0] LOW_BASE  = 32'h0000_0000,
  parameter logic [XLEN-1:0] HIGH_BASE = 32'hFFFF_0000,
  parameter int              IRQ_OFF   = 'h18,
  parameter int              FIQ_OFF   = 'h1C
) (
  input  exc_kind_e       kind,
  input  logic            high_vec,
  output logic [XLEN-1:0] vector
);
  localparam logic [XLEN-1:0] IRQ_OFS = XLEN'(IRQ_OFF);
  localparam logic [XLEN-1:0] FIQ_OFS = XLEN'(FIQ_OFF);

  logic [XLEN-1:0] base;

  assign base = high_vec ? HIGH_BASE : LOW_BASE;

  always_comb begin
    unique case (kind)
      EXC_FIQ: vector = base | FIQ_OFS;
      EXC_IRQ: vector = base | IRQ_OFS;
      default: vector = base;
    endcase
  end
endmodule

// File: rtl/exc_status_build.sv
module exc_status_build
  import exc_seq_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] cur_status,
  input  exc_kind_e       kind,
  input  logic            endian_cfg,
  output logic [XLEN-1:0] next_status
);
  always_comb begin
    next_status             = cur_status;
    next_status[BIT_TSTATE] = 1'b0;
    next_status[BIT_IDIS]   = 1'b1;
    next_status[BIT_ADIS]   = 1'b1;
    next_status[BIT_ENDIAN] = endian_cfg;
    if (kind == EXC_FIQ) begin
      next_status[MODE_W-1:0] = MODE_FIQ;
      next_status[BIT_FDIS]   = 1'b1;
    end else begin
      next_status[MODE_W-1:0] = MODE_IRQ;
    end
  end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_seq_pkg::*;
#(
  parameter int              XLEN      = 32,
  parameter int              LINK_OFF  = 4,
  parameter logic [XLEN-1:0] LOW_BASE  = 32'h0000_0000,
  parameter logic [XLEN-1:0] HIGH_BASE = 32'hFFFF_0000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [XLEN-1:0] cur_pc,
  input  logic [XLEN-1:0] cur_status,
  input  logic            endian_cfg,
  input  logic            high_vec,
  input  logic            irq_req,
  input  logic            fiq_req,
  output logic [XLEN-1:0] new_pc,
  output logic [XLEN-1:0] link,
  output logic [XLEN-1:0] saved_status,
  output logic [XLEN-1:0] status_out,
  output logic            taken,
  output logic            taken_fiq
);
  localparam logic [XLEN-1:0] LINK_STEP = XLEN'(LINK_OFF);

  exc_kind_e       kind;
  logic [XLEN-1:0] vec_d;
  logic [XLEN-1:0] status_d;

  exc_arbiter u_arb (
    .irq_req      (irq_req),
    .fiq_req      (fiq_req),
    .irq_disabled (cur_status[BIT_IDIS]),
    .fiq_disabled (cur_status[BIT_FDIS]),
    .kind         (kind)
  );

  exc_vector_sel #(
    .XLEN      (XLEN),
    .LOW_BASE  (LOW_BASE),
    .HIGH_BASE (HIGH_BASE)
  ) u_vec (
    .kind     (kind),
    .high_vec (high_vec),
    .vector   (vec_d)
  );

  exc_status_build #(.XLEN(XLEN)) u_st (
    .cur_status  (cur_status),
    .kind        (kind),
    .endian_cfg  (endian_cfg),
    .next_status (status_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      new_pc       <= '0;
      link         <= '0;
      saved_status <= '0;
      status_out   <= '0;
      taken        <= 1'b0;
      taken_fiq    <= 1'b0;
    end else begin
      taken     <= (kind != EXC_NONE);
      taken_fiq <= (kind == EXC_FIQ);
      if (kind != EXC_NONE) begin
        new_pc       <= vec_d;
        link         <= cur_pc + LINK_STEP;
        saved_status <= cur_status;
        status_out   <= status_d;
      end
    end
  end
endmodule

// File: rtl/exc_entry_seq_chk.sv
module exc_entry_seq_chk
  import exc_seq_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int LINK_OFF = 4
) (
  input logic            clk,
  input logic            rst,
  input logic [XLEN-1:0] cur_pc,
  input logic [XLEN-1:0] cur_status,
  input logic            endian_cfg,
  input logic            irq_req,
  input logic            fiq_req,
  input logic [XLEN-1:0] new_pc,
  input logic [XLEN-1:0] link,
  input logic [XLEN-1:0] saved_status,
  input logic [XLEN-1:0] status_out,
  input logic            taken,
  input logic            taken_fiq
);
  localparam logic [XLEN-1:0] STEP = XLEN'(LINK_OFF);

  p_link_r2: assert property (@(posedge clk) disable iff (rst)
    taken |-> link == $past(cur_pc) + STEP);

  p_saved_r3: assert property (@(posedge clk) disable iff (rst)
    taken |-> saved_status == $past(cur_status));

  p_status_bits_r4: assert property (@(posedge clk) disable iff (rst)
    taken |-> (!status_out[BIT_TSTATE] && status_out[BIT_IDIS] &&
               status_out[BIT_ADIS] && status_out[BIT_ENDIAN] == $past(endian_cfg)));

  p_irq_mode_r5: assert property (@(posedge clk) disable iff (rst)
    (taken && !taken_fiq) |-> (status_out[MODE_W-1:0] == MODE_IRQ &&
                               status_out[BIT_FDIS] == $past(cur_status[BIT_FDIS])));

  p_fiq_mode_r6: assert property (@(posedge clk) disable iff (rst)
    taken_fiq |-> (status_out[MODE_W-1:0] == MODE_FIQ && status_out[BIT_FDIS]));

  p_fiq_wins_r7: assert property (@(posedge clk) disable iff (rst)
    (fiq_req && !cur_status[BIT_FDIS]) |=> (taken && taken_fiq));

  p_irq_masked_r8: assert property (@(posedge clk) disable iff (rst)
    (irq_req && cur_status[BIT_IDIS] && !(fiq_req && !cur_status[BIT_FDIS])) |=> !taken);

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !taken |-> ($stable(new_pc) && $stable(link) &&
                $stable(saved_status) && $stable(status_out)));

  p_kind_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    taken_fiq |-> taken);
endmodule

bind exc_entry_seq exc_entry_seq_chk #(.XLEN(XLEN), .LINK_OFF(LINK_OFF)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cur_pc       (cur_pc),
  .cur_status   (cur_status),
  .endian_cfg   (endian_cfg),
  .irq_req      (irq_req),
  .fiq_req      (fiq_req),
  .new_pc       (new_pc),
  .link         (link),
  .saved_status (saved_status),
  .status_out   (status_out),
  .taken        (taken),
  .taken_fiq    (taken_fiq)
);

// File: tb/tb_exc_entry_seq.sv
module tb_exc_entry_seq;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    string       tag;
    logic [31:0] pc;
    logic [31:0] lnk;
    logic [31:0] sav;
    logic [31:0] st;
    logic        tk;
    logic        tf;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] cur_pc = '0;
  logic [31:0] cur_status = '0;
  logic        endian_cfg = 1'b0;
  logic        high_vec = 1'b0;
  logic        irq_req = 1'b0;
  logic        fiq_req = 1'b0;
  logic [31:0] new_pc, link, saved_status, status_out;
  logic        taken, taken_fiq;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  exp_t q[$];

  logic [31:0] m_pc = '0, m_lnk = '0, m_sav = '0, m_st = '0;

  exc_entry_seq dut (
    .clk(clk), .rst(rst), .cur_pc(cur_pc), .cur_status(cur_status),
    .endian_cfg(endian_cfg), .high_vec(high_vec), .irq_req(irq_req),
    .fiq_req(fiq_req), .new_pc(new_pc), .link(link),
    .saved_status(saved_status), .status_out(status_out),
    .taken(taken), .taken_fiq(taken_fiq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Driver: sets inputs on the falling edge and pushes the expected result.
  task automatic apply(input string tag, input logic [31:0] pc, input logic [31:0] st,
                       input logic endi, input logic hv, input logic irq, input logic fiq);
    exp_t e;
    logic fiq_ok, irq_ok;
    logic [31:0] ns;
    @(negedge clk);
    cur_pc = pc; cur_status = st; endian_cfg = endi; high_vec = hv;
    irq_req = irq; fiq_req = fiq;
    fiq_ok = fiq && !st[6];
    irq_ok = irq && !st[7];
    e.tag = tag;
    if (fiq_ok || irq_ok) begin
      m_lnk = pc + 32'd4;
      m_sav = st;
      ns = st; ns[5] = 1'b0; ns[7] = 1'b1; ns[8] = 1'b1; ns[9] = endi;
      if (fiq_ok) begin
        ns[4:0] = 5'b10001; ns[6] = 1'b1;
        m_pc = hv ? 32'hFFFF_001C : 32'h0000_001C;
      end else begin
        ns[4:0] = 5'b10010;
        m_pc = hv ? 32'hFFFF_0018 : 32'h0000_0018;
      end
      m_st = ns;
      e.tk = 1'b1; e.tf = fiq_ok;
    end else begin
      e.tk = 1'b0; e.tf = 1'b0;
    end
    e.pc = m_pc; e.lnk = m_lnk; e.sav = m_sav; e.st = m_st;
    q.push_back(e);
  endtask

  // Monitor: compares just after each rising edge.
  always @(posedge clk) begin
    #1;
    if (!rst && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (new_pc !== e.pc || link !== e.lnk || saved_status !== e.sav ||
          status_out !== e.st || taken !== e.tk || taken_fiq !== e.tf) begin
        errors++;
        $display("FAIL %s: act pc=%h lnk=%h sav=%h st=%h tk=%b tf=%b exp pc=%h lnk=%h sav=%h st=%h tk=%b tf=%b",
                 e.tag, new_pc, link, saved_status, status_out, taken, taken_fiq,
                 e.pc, e.lnk, e.sav, e.st, e.tk, e.tf);
      end
    end
  end

  initial begin
    // R1: reset dominates a pending request.
    irq_req = 1'b1; cur_pc = 32'h1234_5678;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (new_pc !== '0 || link !== '0 || saved_status !== '0 || status_out !== '0 ||
        taken !== 1'b0 || taken_fiq !== 1'b0) begin
      errors++;
      $display("FAIL R1: act pc=%h lnk=%h sav=%h st=%h tk=%b tf=%b exp all zero",
               new_pc, link, saved_status, status_out, taken, taken_fiq);
    end
    irq_req = 1'b0; cur_pc = '0;
    rst = 1'b0;

    apply("R9 idle after reset",        32'h0000_0000, 32'h0000_0010, 0, 0, 0, 0);
    apply("R2 R3 R5 irq low vector",    32'h0000_1000, 32'h0000_0010, 0, 0, 1, 0);
    apply("R9 pulse ends, hold",        32'h0000_2000, 32'h0000_0010, 0, 0, 0, 0);
    apply("R5 irq high vector",         32'h8000_0040, 32'hA5A5_0030, 0, 1, 1, 0);
    apply("R6 fiq low vector",          32'h0000_3000, 32'h0000_0010, 0, 0, 0, 1);
    apply("R6 fiq high vector",         32'h0000_4444, 32'h0000_0013, 1, 1, 0, 1);
    apply("R7 both accepted",           32'h0000_5000, 32'h0000_0010, 0, 0, 1, 1);
    apply("R8 irq ignored bit7",        32'h0000_6000, 32'h0000_0090, 0, 0, 1, 0);
    apply("R8 fiq ignored bit6",        32'h0000_7000, 32'h0000_0050, 1, 1, 0, 1);
    apply("R8 R7 fiq off, irq taken",   32'h0000_7100, 32'h0000_0050, 0, 0, 1, 1);
    apply("R8 both ignored",            32'h0000_7200, 32'h0000_00D0, 1, 1, 1, 1);
    apply("R4 endian and upper bits",   32'h0000_8000, 32'hF0F0_FC3F, 1, 0, 1, 0);
    apply("R2 link wraps",              32'hFFFF_FFFC, 32'h1234_0010, 0, 0, 0, 1);
    apply("R9 back-to-back entry",      32'h0000_9000, 32'h0000_0010, 0, 1, 1, 0);
    apply("R9 idle hold",               32'h0000_A000, 32'h0000_0010, 0, 0, 0, 0);
    @(negedge clk);
    irq_req = 1'b0; fiq_req = 1'b0;
    wait (q.size() == 0);
    @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: act timeout exp completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule